// File: doc/BRIEF.md
# Serial Byte Capture and Note Message Sequencer

This block sits behind a serial receiver that raises a ready flag when a byte has arrived and keeps it raised until told to drop it. On the first clock edge that sees the flag high, the block stores the incoming byte and returns a clear strobe to the receiver. The strobe is high for exactly one clock. The block then stays idle until it has seen the flag low, so a flag that is slow to fall cannot produce a second capture.

Each capture steps a small message sequencer. The sequencer tags the captured byte as a status byte, a key number or a velocity. A byte with its top bit set is always a status byte and restarts the message. A data byte that arrives while no message is open is tagged as unused. When the velocity byte is captured, the block emits a one-cycle completion pulse. At the same edge it publishes the key number and the velocity of the finished message, and it holds both values until the next message completes.

Top module: `midi_byte_capture`

## Requirements
- R1: On a rising edge where `flag` is high and the block is armed, `data_in` is stored and appears on `cap_byte` after that edge. `cap_byte` keeps this value until the next capture.
- R2: `clr_flag` goes high in the cycle after a capture edge and stays high for exactly one clock.
- R3: After a capture, `flag` being high at later edges causes no capture and no strobe, even if `data_in` changes. The block re-arms at the first edge where `flag` is low. One low cycle is enough for the next high flag to be captured.
- R4: Each capture moves the sequencer exactly one step. `byte_role` shows the role of the byte in `cap_byte` with this encoding: 2'b00 is unused data, 2'b01 is status, 2'b10 is key number and 2'b11 is velocity. Within a message the order is status, then key, then velocity, after which the sequencer waits for a new status byte.
- R5: A captured byte with bit 7 set is tagged status (2'b01), whatever step the sequencer is on. The next data byte is then taken as the key number.
- R6: A captured byte with bit 7 clear that arrives while the sequencer waits for a status byte is tagged 2'b00. It raises no `msg_done`, and the following data byte is again tagged 2'b00.
- R7: Capturing a velocity byte raises `msg_done` for one cycle, in the same cycle as `clr_flag`. At the same time `msg_key` and `msg_vel` take the low 7 bits of that message's key and velocity bytes. Neither value changes at any other time.
- R8: While `rst` is high at a rising edge, the block clears `cap_byte`, `clr_flag`, `byte_role`, `msg_done`, `msg_key` and `msg_vel` to zero. It also arms capture and returns the sequencer to waiting for a status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flag | input | 1 | Ready flag from the serial receiver |
| data_in | input | 8 | Received byte, valid while `flag` is high |
| cap_byte | output | 8 | Last captured byte |
| clr_flag | output | 1 | One-cycle strobe telling the receiver to drop `flag` |
| byte_role | output | 2 | Role of `cap_byte`: 00 unused, 01 status, 10 key, 11 velocity |
| msg_done | output | 1 | One-cycle pulse when a velocity byte completes a message |
| msg_key | output | 7 | Key number of the last completed message |
| msg_vel | output | 7 | Velocity of the last completed message |

## Verification
The assertions take for granted that `flag` and `data_in` change only away from the rising edge. They also assume the receiver lowers `flag` before a reset ends, because an armed block captures a flag that is still high right after reset. The stimulus drives every input on the falling edge. It holds `flag` high for zero to several extra cycles after each strobe, and it changes `data_in` during those cycles. Before each reset it returns `flag` to low.

// File: rtl/midi_cap_pkg.sv
package midi_cap_pkg;

    localparam int BYTE_W = 8;
    localparam int DATA_W = BYTE_W - 1;

    typedef enum logic [1:0] {
        ROLE_NONE   = 2'b00,
        ROLE_STATUS = 2'b01,
        ROLE_KEY    = 2'b10,
        ROLE_VEL    = 2'b11
    } role_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_KEY  = 2'd1,
        SQ_VEL  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] key;
        logic [DATA_W-1:0] vel;
    } note_t;

    function automatic logic is_status(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1];
    endfunction

    function automatic logic [DATA_W-1:0] payload(input logic [BYTE_W-1:0] b);
        return b[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/mc_arm_unit.sv
module mc_arm_unit (
    input  logic clk,
    input  logic rst,
    input  logic flag,
    output logic take,
    output logic strobe
);
    logic armed_q;
    logic strobe_q;

    assign take   = armed_q & flag;
    assign strobe = strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b1;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= take;
            if (take) begin
                armed_q <= 1'b0;
            end else if (!flag) begin
                armed_q <= 1'b1;
            end
        end
    end

    // R2
    strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> !strobe_q);

    // R3
    no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_q && flag) |=> !strobe_q);

endmodule

// File: rtl/mc_byte_reg.sv
module mc_byte_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    assign q = q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (load) begin
            q_r <= d;
        end
    end

    // R1
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q_r));

endmodule

// File: rtl/mc_msg_seq.sv
module mc_msg_seq
    import midi_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    output role_t             role,
    output logic              done,
    output note_t             note
);
    seq_state_t        state_q;
    role_t             role_q;
    logic              done_q;
    logic [DATA_W-1:0] key_pend_q;
    note_t             note_q;

    assign role = role_q;
    assign done = done_q;
    assign note = note_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_IDLE;
            role_q     <= ROLE_NONE;
            done_q     <= 1'b0;
            key_pend_q <= '0;
            note_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (take) begin
                if (is_status(byte_in)) begin
                    role_q  <= ROLE_STATUS;
                    state_q <= SQ_KEY;
                end else begin
                    case (state_q)
                        SQ_KEY: begin
                            role_q     <= ROLE_KEY;
                            key_pend_q <= payload(byte_in);
                            state_q    <= SQ_VEL;
                        end
                        SQ_VEL: begin
                            role_q     <= ROLE_VEL;
                            done_q     <= 1'b1;
                            note_q.key <= key_pend_q;
                            note_q.vel <= payload(byte_in);
                            state_q    <= SQ_IDLE;
                        end
                        default: begin
                            role_q  <= ROLE_NONE;
                            state_q <= SQ_IDLE;
                        end
                    endcase
                end
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7
    done_role_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (role_q == ROLE_VEL));

    // R6
    idle_data_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !is_status(byte_in) && state_q == SQ_IDLE) |=> !done_q);

endmodule

// File: rtl/midi_byte_capture.sv
module midi_byte_capture
    import midi_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flag,
    input  logic [BYTE_W-1:0] data_in,
    output logic [BYTE_W-1:0] cap_byte,
    output logic              clr_flag,
    output logic [1:0]        byte_role,
    output logic              msg_done,
    output logic [DATA_W-1:0] msg_key,
    output logic [DATA_W-1:0] msg_vel
);
    logic  take;
    role_t role;
    note_t note;

    mc_arm_unit arm_i (
        .clk    (clk),
        .rst    (rst),
        .flag   (flag),
        .take   (take),
        .strobe (clr_flag)
    );

    mc_byte_reg #(.W(BYTE_W)) byte_i (
        .clk  (clk),
        .rst  (rst),
        .load (take),
        .d    (data_in),
        .q    (cap_byte)
    );

    mc_msg_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .byte_in (data_in),
        .role    (role),
        .done    (msg_done),
        .note    (note)
    );

    assign byte_role = role;
    assign msg_key   = note.key;
    assign msg_vel   = note.vel;

    // R7
    done_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        msg_done |-> clr_flag);

    // R7
    note_stable_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (msg_done || ($stable(msg_key) && $stable(msg_vel))));

    // R5
    status_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_flag && cap_byte[BYTE_W-1]) |-> (byte_role == 2'b01));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!clr_flag && !msg_done && cap_byte == '0));

endmodule

// File: tb/midi_byte_capture_tb_top.sv
module midi_byte_capture_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flag = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] cap_byte;
    logic       clr_flag;
    logic [1:0] byte_role;
    logic       msg_done;
    logic [6:0] msg_key;
    logic [6:0] msg_vel;

    int n_chk = 0;
    int n_fail = 0;

    logic [6:0] exp_key = 7'd0;
    logic [6:0] exp_vel = 7'd0;
    logic [6:0] pend    = 7'd0;

    always #10 clk = ~clk;

    midi_byte_capture dut_i (
        .clk       (clk),
        .rst       (rst),
        .flag      (flag),
        .data_in   (data_in),
        .cap_byte  (cap_byte),
        .clr_flag  (clr_flag),
        .byte_role (byte_role),
        .msg_done  (msg_done),
        .msg_key   (msg_key),
        .msg_vel   (msg_vel)
    );

    // {data[7:0], role[1:0], done, hold[2:0]}
    localparam int NV = 10;
    localparam logic [13:0] VEC [0:NV-1] = '{
        {8'h40, 2'b00, 1'b0, 3'd1},
        {8'h90, 2'b01, 1'b0, 3'd0},
        {8'h3C, 2'b10, 1'b0, 3'd3},
        {8'h64, 2'b11, 1'b1, 3'd2},
        {8'h22, 2'b00, 1'b0, 3'd0},
        {8'h80, 2'b01, 1'b0, 3'd4},
        {8'h45, 2'b10, 1'b0, 3'd1},
        {8'h95, 2'b01, 1'b0, 3'd0},
        {8'h30, 2'b10, 1'b0, 3'd2},
        {8'h7F, 2'b11, 1'b1, 3'd5}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic [1:0] er,
                        input bit ed, input int hold);
        @(negedge clk);
        flag = 1'b1;
        data_in = d;
        if (er == 2'b10) pend = d[6:0];
        if (ed) begin
            exp_key = pend;
            exp_vel = d[6:0];
        end
        @(negedge clk);
        chk(clr_flag == 1'b1, "R2", "clr_flag", clr_flag, 1);
        chk(cap_byte == d, "R1", "cap_byte", cap_byte, d);
        chk(byte_role == er, "R4", "byte_role", byte_role, er);
        chk(msg_done == ed, "R7", "msg_done", msg_done, ed);
        chk(msg_key == exp_key, "R7", "msg_key", msg_key, exp_key);
        chk(msg_vel == exp_vel, "R7", "msg_vel", msg_vel, exp_vel);
        for (int i = 0; i < hold; i++) begin
            data_in = d ^ 8'h5A;
            @(negedge clk);
            chk(clr_flag == 1'b0, "R3", "clr_flag held", clr_flag, 0);
            chk(cap_byte == d, "R3", "cap_byte held", cap_byte, d);
            chk(msg_done == 1'b0, "R7", "msg_done held", msg_done, 0);
        end
        flag = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(clr_flag == 0 && msg_done == 0, "R8", "strobes in reset",
            {clr_flag, msg_done}, 0);
        chk(cap_byte == 0, "R8", "cap_byte in reset", cap_byte, 0);
        chk(byte_role == 0, "R8", "role in reset", byte_role, 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            send(VEC[v][13:6], VEC[v][5:4], VEC[v][3], int'(VEC[v][2:0]));
        end

        // R3: idle with flag low, nothing changes
        repeat (4) begin
            @(negedge clk);
            chk(clr_flag == 0, "R3", "idle clr_flag", clr_flag, 0);
            chk(cap_byte == 8'h7F, "R3", "idle cap_byte", cap_byte, 8'h7F);
        end

        // R6: two data bytes while waiting for status
        send(8'h11, 2'b00, 1'b0, 0);
        send(8'h12, 2'b00, 1'b0, 1);

        // R8: reset mid-message
        send(8'h90, 2'b01, 1'b0, 0);
        send(8'h11, 2'b10, 1'b0, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_key = 7'd0;
        exp_vel = 7'd0;
        chk(cap_byte == 0 && clr_flag == 0, "R8", "cap/clr after reset",
            {cap_byte, clr_flag}, 0);
        chk(msg_key == 0 && msg_vel == 0, "R8", "note after reset",
            {msg_key, msg_vel}, 0);
        chk(byte_role == 0 && msg_done == 0, "R8", "role/done after reset",
            {byte_role, msg_done}, 0);
        // R8: sequencer back to waiting for status
        send(8'h33, 2'b00, 1'b0, 0);

        // R5: status restart right before velocity, then a full message
        send(8'hB0, 2'b01, 1'b0, 0);
        send(8'h05, 2'b10, 1'b0, 0);
        send(8'hC1, 2'b01, 1'b0, 2);
        send(8'h06, 2'b10, 1'b0, 0);
        send(8'h07, 2'b11, 1'b1, 0);
        @(negedge clk);
        chk(msg_done == 0, "R7", "done one cycle", msg_done, 0);
        chk(clr_flag == 0, "R2", "strobe one cycle", clr_flag, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule